// File: doc/BRIEF.md
# Buck Regulator Start-Up and Hiccup Retry Sequencer

This block is the digital start-up controller for a synchronous buck regulator. It waits until the supply flag and the enable flag are both valid. It then runs a fixed settling delay and asks an external current-limit sampler for one sample. When the sampler reports done, it steps a 64-level soft-start reference code up to full scale. Every delay is a counter running on the system clock, sized from the clock rate in kHz and a duration in microseconds. None of the timing depends on the switching frequency.

A comparator flag tells the block when the ramping reference has passed the voltage already on the output. The gate drivers stay off until that flag is seen, or until the ramp completes if it never is, so a pre-charged output is not discharged. An overcurrent trip during the ramp or in regulation turns the gates off. The block then waits for two dummy soft-start periods and starts a new real ramp, without taking a fresh current-limit sample. This repeats for as long as the fault persists. Losing either the supply flag or the enable flag returns the block to idle, and the next start repeats the full sequence.

Top module: `pwr_seq_hiccup`

## Requirements
- R1: After reset the state output reads idle (code 0), the reference code is 0, and both the gate enable and the sample strobe are low.
- R2: The block leaves idle only when `por_ok` and `en_ok` are both high. It enters the delay state (code 1) on the next clock edge, whichever of the two flags rose last.
- R3: The delay state lasts DELAY_CYC cycles. The block then enters the sample state (code 2), and `smp_start` is high for exactly that first cycle.
- R4: The block stays in the sample state until `smp_done` is high. On the next edge it enters the ramp state (code 3) with the reference code at 0.
- R5: In the ramp state the reference code rises by one every STEP_CYC cycles. After 64 × STEP_CYC cycles the block enters regulation (code 4), and the code holds at 63.
- R6: During the ramp, `gate_en` stays low until `ramp_above` is sampled high. It is high from the following cycle and stays high through the rest of the ramp.
- R7: If `ramp_above` is never seen during the ramp, `gate_en` stays low for the whole ramp and goes high on entry to regulation.
- R8: `ocp_trip` sampled high in the ramp or regulation state moves the block to the retry state (code 5) on the next edge, with `gate_en` low and the code at 0.
- R9: The retry state lasts 2 × 64 × STEP_CYC cycles and then enters the ramp state directly, with no `smp_start` pulse.
- R10: `por_ok` or `en_ok` low in any state returns the block to idle on the next edge, with the code at 0 and the gates off. The next start runs the delay and a new sample strobe.
- R11: `ocp_trip` has no effect in the delay, sample and retry states. The state sequence and its timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply above power-on threshold |
| en_ok | input | 1 | Enable pin above disable threshold |
| ocp_trip | input | 1 | Overcurrent comparator trip |
| smp_done | input | 1 | Current-limit sampler finished |
| ramp_above | input | 1 | Soft-start reference exceeds output voltage |
| smp_start | output | 1 | One-cycle request to start a current-limit sample |
| ss_code | output | CODE_W | Soft-start reference code |
| gate_en | output | 1 | Permission for the gate drivers to switch |
| state_o | output | 3 | Current sequencer state |

## Verification
The bench builds the block with CLK_KHZ=1000, DELAY_US=40 and RAMP_US=256. That gives a 40-cycle delay, a 4-cycle ramp step, a 256-cycle ramp and a 512-cycle retry. At these sizes a run can walk several complete start-ups, retries and full ramps cycle by cycle. The ramp crossing point, the sampler wait and the trip instant are drawn at random, and boundary cases are directed: a crossing on the first cycle, no crossing at all, a trip during retry, and flag loss mid-ramp.

// File: rtl/pwr_seq_hiccup.sv
`timescale 1ns/1ps
module pwr_seq_hiccup #(
  parameter int CLK_KHZ  = 50000,
  parameter int DELAY_US = 6800,
  parameter int RAMP_US  = 6800,
  parameter int CODE_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_ok,
  input  logic              en_ok,
  input  logic              ocp_trip,
  input  logic              smp_done,
  input  logic              ramp_above,
  output logic              smp_start,
  output logic [CODE_W-1:0] ss_code,
  output logic              gate_en,
  output logic [2:0]        state_o
);
  localparam int STEPS     = 1 << CODE_W;
  localparam longint DLY_L = longint'(CLK_KHZ) * DELAY_US / 1000;
  localparam longint RMP_L = longint'(CLK_KHZ) * RAMP_US / 1000;
  localparam int DELAY_CYC = (DLY_L < 1) ? 1 : int'(DLY_L);
  localparam int STEP_CYC  = (RMP_L / STEPS < 1) ? 1 : int'(RMP_L / STEPS);
  localparam int HIC_CYC   = 2 * STEPS * STEP_CYC;
  localparam int CNT_MAX   = (DELAY_CYC > HIC_CYC) ? DELAY_CYC : HIC_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_DLY = 3'd1, S_SMP = 3'd2,
    S_RAMP = 3'd3, S_REG = 3'd4, S_HIC = 3'd5
  } st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] code;
  logic              gate_q, strobe;
  wire               live = por_ok && en_ok;
  wire               step_end = (cnt == CNT_W'(STEP_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; code <= '0; gate_q <= 1'b0; strobe <= 1'b0;
    end else begin
      strobe <= 1'b0;
      if (!live) begin
        st <= S_IDLE; cnt <= '0; code <= '0; gate_q <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            st <= S_DLY; cnt <= '0;
          end
          S_DLY: begin
            if (cnt == CNT_W'(DELAY_CYC - 1)) begin
              st <= S_SMP; cnt <= '0; strobe <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_SMP: begin
            if (smp_done) begin
              st <= S_RAMP; cnt <= '0; code <= '0; gate_q <= 1'b0;
            end
          end
          S_RAMP: begin
            if (ocp_trip) begin
              st <= S_HIC; cnt <= '0; code <= '0; gate_q <= 1'b0;
            end else begin
              if (ramp_above) gate_q <= 1'b1;
              if (step_end) begin
                cnt <= '0;
                if (code == CODE_TOP) begin
                  st <= S_REG; gate_q <= 1'b1;
                end else code <= code + 1'b1;
              end else cnt <= cnt + 1'b1;
            end
          end
          S_REG: begin
            if (ocp_trip) begin
              st <= S_HIC; cnt <= '0; code <= '0; gate_q <= 1'b0;
            end
          end
          S_HIC: begin
            if (cnt == CNT_W'(HIC_CYC - 1)) begin
              st <= S_RAMP; cnt <= '0; code <= '0; gate_q <= 1'b0;
            end else cnt <= cnt + 1'b1;
          end
          default: begin
            st <= S_IDLE; cnt <= '0; code <= '0; gate_q <= 1'b0;
          end
        endcase
      end
    end
  end

  assign smp_start = strobe;
  assign ss_code   = code;
  assign gate_en   = gate_q;
  assign state_o   = st;

  // R6
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RAMP && st != S_REG) |-> !gate_en);
  // R8
  trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ocp_trip && (st == S_RAMP || st == S_REG)) |=> (st == S_HIC && !gate_en && ss_code == '0));
  // R10
  drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (st == S_IDLE && ss_code == '0 && !gate_en));
  // R5
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAMP && live && !ocp_trip) |=> (ss_code == $past(ss_code) || ss_code == $past(ss_code) + 1'b1));
  // R3
  strobe_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_start |-> (st == S_SMP && $past(st) == S_DLY));
  // R9
  retry_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HIC) |=> (st == S_HIC || st == S_RAMP || st == S_IDLE) && !smp_start);
  // R6
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && live && !ocp_trip && st == S_RAMP) |=> gate_en);
endmodule

// File: tb/test_pwr_seq_hiccup.sv
`timescale 1ns/1ps
module test_pwr_seq_hiccup;
  localparam int KHZ = 1000, DUS = 40, RUS = 256;
  localparam int DLY = KHZ * DUS / 1000;
  localparam int STP = (KHZ * RUS / 1000) / 64;
  localparam int RCY = 64 * STP;
  localparam int HCY = 2 * RCY;

  logic clk = 1'b0, rst_n = 1'b0;
  logic por_ok = 1'b0, en_ok = 1'b0, ocp_trip = 1'b0, smp_done = 1'b0, ramp_above = 1'b0;
  logic smp_start, gate_en;
  logic [5:0] ss_code;
  logic [2:0] state_o;
  int checks = 0, errors = 0, strobes = 0;

  always #2.5 clk = ~clk;

  pwr_seq_hiccup #(.CLK_KHZ(KHZ), .DELAY_US(DUS), .RAMP_US(RUS), .CODE_W(6)) i_pwr_seq_hiccup (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_ok(en_ok), .ocp_trip(ocp_trip),
    .smp_done(smp_done), .ramp_above(ramp_above), .smp_start(smp_start),
    .ss_code(ss_code), .gate_en(gate_en), .state_o(state_o));

  always @(posedge clk) if (smp_start) strobes++;

  function automatic int exp_code(int j); return j / STP; endfunction
  function automatic int exp_gate(int j, int c); return (c >= 0 && j > c) ? 1 : 0; endfunction

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic boot(int w);
    int s0;
    s0 = strobes;
    tick(1);      chk("R2 delay entry", int'(state_o), 1);
    tick(DLY-1);  chk("R3 still delay", int'(state_o), 1);
                  chk("R3 no early strobe", int'(smp_start), 0);
    tick(1);      chk("R3 sample entry", int'(state_o), 2);
                  chk("R3 strobe high", int'(smp_start), 1);
    tick(1);      chk("R3 strobe one cycle", int'(smp_start), 0);
    tick(w);      chk("R4 waits for done", int'(state_o), 2);
    smp_done = 1'b1;
    tick(1);      chk("R4 ramp entry", int'(state_o), 3);
                  chk("R4 code zero", int'(ss_code), 0);
    smp_done = 1'b0;
    chk("R10 one new sample", strobes - s0, 1);
  endtask

  task automatic run_ramp(int c);
    for (int j = 0; j < RCY; j++) begin
      chk("R5 ramp code", int'(ss_code), exp_code(j));
      chk(c < 0 ? "R7 gates held" : "R6 gate vs crossing", int'(gate_en), exp_gate(j, c));
      if (j == c) ramp_above = 1'b1;
      tick(1);
    end
    chk("R5 regulation entry", int'(state_o), 4);
    chk("R5 code held top", int'(ss_code), 63);
    chk("R7 gate on in regulation", int'(gate_en), 1);
    ramp_above = 1'b0;
  endtask

  task automatic retry(bit poke);
    int s0;
    s0 = strobes;
    tick(1);
    chk("R8 retry state", int'(state_o), 5);
    chk("R8 gate off", int'(gate_en), 0);
    chk("R8 code cleared", int'(ss_code), 0);
    ocp_trip = 1'b0;
    if (poke) begin
      tick(10); ocp_trip = 1'b1; tick(1); ocp_trip = 1'b0;
      chk("R11 trip ignored in retry", int'(state_o), 5);
      tick(HCY - 12);
    end else tick(HCY - 1);
    chk("R9 retry length", int'(state_o), 5);
    tick(1);
    chk("R9 back to ramp", int'(state_o), 3);
    chk("R9 no resample", strobes - s0, 0);
  endtask

  initial begin
    int c, r;
    void'($urandom(32'd4711));
    tick(3);
    chk("R1 state", int'(state_o), 0);
    chk("R1 code", int'(ss_code), 0);
    chk("R1 gate", int'(gate_en), 0);
    chk("R1 strobe", int'(smp_start), 0);
    rst_n = 1'b1;
    por_ok = 1'b1;
    tick(5); chk("R2 idle without enable", int'(state_o), 0);
    en_ok = 1'b1;
    boot(3);
    run_ramp(0);
    tick(20); chk("R5 regulation stable", int'(state_o), 4);
    ocp_trip = 1'b1;
    retry(1'b1);
    run_ramp(-1);
    ocp_trip = 1'b1;
    retry(1'b0);
    r = int'($urandom_range(1, RCY - 2));
    tick(r); ocp_trip = 1'b1;
    retry(1'b0);
    run_ramp(int'($urandom_range(0, RCY - 1)));
    en_ok = 1'b0;
    tick(1);
    chk("R10 enable loss idle", int'(state_o), 0);
    chk("R10 code cleared", int'(ss_code), 0);
    chk("R10 gate off", int'(gate_en), 0);
    en_ok = 1'b1; ocp_trip = 1'b1;
    tick(1);   chk("R11 delay entry with trip", int'(state_o), 1);
    tick(DLY); chk("R11 trip ignored in delay", int'(state_o), 2);
    tick(3);   chk("R11 trip ignored in sample", int'(state_o), 2);
    ocp_trip = 1'b0; smp_done = 1'b1;
    tick(1);   chk("R4 ramp after done", int'(state_o), 3);
    smp_done = 1'b0;
    tick(int'($urandom_range(5, RCY - 5)));
    por_ok = 1'b0;
    tick(1);
    chk("R10 supply loss idle", int'(state_o), 0);
    chk("R10 supply loss gate", int'(gate_en), 0);
    tick(4); chk("R2 waits for supply", int'(state_o), 0);
    por_ok = 1'b1;
    boot(0);
    for (int k = 0; k < 3; k++) begin
      c = ($urandom_range(0, 3) == 0) ? -1 : int'($urandom_range(0, RCY - 1));
      run_ramp(c);
      ocp_trip = 1'b1;
      retry(1'b0);
      en_ok = 1'b0; tick(1);
      chk("R10 restart idle", int'(state_o), 0);
      en_ok = 1'b1;
      boot(int'($urandom_range(0, 6)));
    end
    run_ramp(RCY - 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule